// File: doc/BRIEF.md
# Halfword-Splitting Access Sequencer with Lane Swapping

This block connects a 32-bit little-endian host slave port to a peripheral module bus whose devices are 16 or 32 bits wide. Every host request, a long-word address with four byte enables and write data, becomes one or two strobe/acknowledge cycles on the peripheral side. On a 16-bit device a long word goes out as two halfword cycles: the low half first at the even halfword address, then the high half at the next halfword address. A halfword with no enabled byte is not issued.

The host address has three fields. The top bit picks the access width: a 1 selects the 32-bit window and a 0 selects the 16-bit window. The next bits are the slot number, and the low bits are the long-word index inside the slot. The host can mix the two windows freely without touching any control input. Each slot has its own byte-swap pin and word-swap pin. In the 32-bit window, two neighbouring slots (2k, 2k+1) act as one device, and the pins of the odd slot of the pair apply. Writes apply the word swap and then the byte swap. Reads undo the byte swap first and then the word swap, so a write and a read-back with the same settings return the host's data.

Top module: `hw_split_bridge`

## Requirements
- R1: In the 16-bit window, a write or read whose mapped strobes cover both halfwords issues two peripheral cycles. The first carries mapped bits 15:0 at halfword address 2·L. The second carries mapped bits 31:16 at 2·L+1. Narrow cycles use only p_wdata[15:0] and p_be[1:0], and hold the upper lanes at zero.
- R2: The peripheral address is in halfword units, formed as {L, h}. L is the host long-word index and h is 1 only for the upper halfword of a narrow access. Any index L may start a split access.
- R3: Peripheral strobes are the host byte enables moved by the same byte mapping as the data. In the 16-bit window, a request whose mapped strobes lie within one halfword issues one cycle, for that halfword. All-zero enables issue one lower-half cycle with no strobe set.
- R4: In the 32-bit window every request is a single cycle with p_wide=1, the full 32-bit data and four strobes, at even halfword address 2·L.
- R5: In the 32-bit window, the swap pins of odd slot (s | 1) govern the access, p_sel carries s | 1, and the pins of the even slot have no effect.
- R6: Byte swap on a 16-bit access exchanges bytes within each halfword. Host 0x1234 in the low half appears on the bus as 0x3412.
- R7: Byte swap on a 32-bit access reverses all four bytes. Host 0x12345678 appears on the bus as 0x78563412.
- R8: Word swap exchanges the two halfwords. When both swaps are on, a write applies word swap first and byte swap second.
- R9: Read data is taken from the bus, the byte swap is undone, then the word swap is undone, and every byte whose host enable is 0 returns as zero. A write and a read-back with the same settings return the written data under its enables.
- R10: h_ack is a one-cycle pulse in the cycle after the last peripheral acknowledge of the request. A request with n peripheral cycles sees h_ack on the (2n+1)th clock after it is accepted, when the device acknowledges one cycle after each strobe.
- R11: After reset, p_stb and h_ack are low. While p_stb is high and no acknowledge has arrived, the address, strobes and write data stay unchanged.
- R12: With both swap pins of the governing slot low, data passes byte for byte in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_req | input | 1 | Host request, held until h_ack |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | 1+SLOT_W+LW_W | {window, slot, long-word index} |
| h_be | input | 4 | Host byte enables |
| h_wdata | input | 32 | Host write data |
| h_ack | output | 1 | One-cycle completion pulse |
| h_rdata | output | 32 | Read data, valid with h_ack |
| bswap | input | SLOTS | Per-slot byte-swap enable |
| wswap | input | SLOTS | Per-slot word-swap enable |
| p_stb | output | 1 | Peripheral cycle strobe |
| p_we | output | 1 | Peripheral write |
| p_wide | output | 1 | 32-bit cycle |
| p_sel | output | SLOT_W | Selected slot |
| p_addr | output | LW_W+1 | Halfword address |
| p_be | output | 4 | Peripheral byte strobes |
| p_wdata | output | 32 | Peripheral write data |
| p_ack | input | 1 | Peripheral acknowledge |
| p_rdata | input | 32 | Peripheral read data |

## Verification
Two events share a single clock: the acknowledge of the lower half of a split and the move to the upper halfword, where the address, strobes and data lanes all change. Every split request in the 16-bit window sets this up. The result is judged three ways: the order of the logged addresses, the bytes left in the bench's device memory, and the data reassembled on read-back. The bench sweeps all byte-enable patterns and swap settings in both windows. The even slot of each pair is given swap settings different from its partner, so that a wrong control choice shows in the stored bytes.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_RESP = 2'd2
    } seq_state_e;

    typedef enum logic {
        PH_LO = 1'b0,
        PH_HI = 1'b1
    } half_e;

    typedef struct packed {
        logic wide;
        logic bsw;
        logic wsw;
    } lane_cfg_t;

    function automatic logic [31:0] word_swap(input logic [31:0] d);
        return {d[15:0], d[31:16]};
    endfunction

    function automatic logic [31:0] byte_swap(input logic [31:0] d, input logic wide);
        if (wide)
            return {d[7:0], d[15:8], d[23:16], d[31:24]};
        return {d[23:16], d[31:24], d[7:0], d[15:8]};
    endfunction

    // Strobes follow the same lane movement as the data (write direction).
    function automatic logic [3:0] strobe_map(input logic [3:0] be, input lane_cfg_t c);
        logic [3:0] s;
        s = c.wsw ? {be[1:0], be[3:2]} : be;
        if (c.bsw)
            s = c.wide ? {s[0], s[1], s[2], s[3]} : {s[2], s[3], s[0], s[1]};
        return s;
    endfunction

    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++)
            m[8*i +: 8] = {8{be[i]}};
        return m;
    endfunction

endpackage

// File: rtl/hsb_decode.sv
module hsb_decode
    import hsb_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int LW_W   = 2,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int AW     = 1 + SLOT_W + LW_W
) (
    input  logic [AW-1:0]     addr,
    input  logic [SLOTS-1:0]  bswap,
    input  logic [SLOTS-1:0]  wswap,
    output lane_cfg_t         cfg,
    output logic [SLOT_W-1:0] slot,
    output logic [LW_W-1:0]   lw
);
    logic              wide;
    logic [SLOT_W-1:0] raw_slot;

    assign wide     = addr[AW-1];
    assign raw_slot = addr[LW_W +: SLOT_W];
    assign lw       = addr[LW_W-1:0];
    // A pair of slots behaves as one wide device; its odd member owns the controls.
    assign slot     = wide ? (raw_slot | SLOT_W'(1)) : raw_slot;

    always_comb begin
        cfg.wide = wide;
        cfg.bsw  = bswap[slot];
        cfg.wsw  = wswap[slot];
    end
endmodule

// File: rtl/hsb_lane_swap.sv
module hsb_lane_swap
    import hsb_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  logic [31:0] din,
    input  lane_cfg_t   cfg,
    output logic [31:0] dout
);
    logic [31:0] mid;

    generate
        if (!INVERSE) begin : g_fwd
            always_comb begin
                mid  = cfg.wsw ? word_swap(din) : din;
                dout = cfg.bsw ? byte_swap(mid, cfg.wide) : mid;
            end
        end else begin : g_inv
            always_comb begin
                mid  = cfg.bsw ? byte_swap(din, cfg.wide) : din;
                dout = cfg.wsw ? word_swap(mid) : mid;
            end
        end
    endgenerate
endmodule

// File: rtl/hsb_seq.sv
module hsb_seq
    import hsb_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int LW_W   = 2,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int PAW    = LW_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              h_req,
    input  logic              h_we,
    input  lane_cfg_t         cfg,
    input  logic [SLOT_W-1:0] slot,
    input  logic [LW_W-1:0]   lw,
    input  logic [3:0]        hbe,
    input  logic [3:0]        mbe,
    input  logic [31:0]       mwd,
    output logic              h_ack,
    output logic [31:0]       raw_q,
    output logic [3:0]        hbe_q,
    output lane_cfg_t         cfg_q,
    output logic              p_stb,
    output logic              p_we,
    output logic              p_wide,
    output logic [SLOT_W-1:0] p_sel,
    output logic [PAW-1:0]    p_addr,
    output logic [3:0]        p_be,
    output logic [31:0]       p_wdata,
    input  logic              p_ack,
    input  logic [31:0]       p_rdata
);
    seq_state_e        st_q;
    half_e             ph_q;
    logic              need_hi_q;
    logic              we_q;
    logic [SLOT_W-1:0] slot_q;
    logic [LW_W-1:0]   lw_q;
    logic [3:0]        mbe_q;
    logic [31:0]       mwd_q;
    logic              lo_any;
    logic              hi_any;

    assign lo_any = (mbe[1:0] != 2'b00) || (mbe == 4'b0000);
    assign hi_any = (mbe[3:2] != 2'b00);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            ph_q      <= PH_LO;
            need_hi_q <= 1'b0;
            we_q      <= 1'b0;
            cfg_q     <= '0;
            slot_q    <= '0;
            lw_q      <= '0;
            mbe_q     <= '0;
            mwd_q     <= '0;
            hbe_q     <= '0;
            raw_q     <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (h_req) begin
                        we_q      <= h_we;
                        cfg_q     <= cfg;
                        slot_q    <= slot;
                        lw_q      <= lw;
                        mbe_q     <= mbe;
                        mwd_q     <= mwd;
                        hbe_q     <= hbe;
                        raw_q     <= '0;
                        ph_q      <= (cfg.wide || lo_any) ? PH_LO : PH_HI;
                        need_hi_q <= !cfg.wide && lo_any && hi_any;
                        st_q      <= ST_BUS;
                    end
                end
                ST_BUS: begin
                    if (p_ack) begin
                        if (cfg_q.wide)
                            raw_q <= p_rdata;
                        else if (ph_q == PH_LO)
                            raw_q[15:0] <= p_rdata[15:0];
                        else
                            raw_q[31:16] <= p_rdata[15:0];
                        if (ph_q == PH_LO && need_hi_q)
                            ph_q <= PH_HI;
                        else
                            st_q <= ST_RESP;
                    end
                end
                ST_RESP: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign p_stb  = (st_q == ST_BUS);
    assign h_ack  = (st_q == ST_RESP);
    assign p_we   = we_q;
    assign p_wide = cfg_q.wide;
    assign p_sel  = slot_q;
    assign p_addr = {lw_q, (!cfg_q.wide && ph_q == PH_HI)};

    always_comb begin
        if (cfg_q.wide) begin
            p_be    = mbe_q;
            p_wdata = mwd_q;
        end else if (ph_q == PH_HI) begin
            p_be    = {2'b00, mbe_q[3:2]};
            p_wdata = {16'h0000, mwd_q[31:16]};
        end else begin
            p_be    = {2'b00, mbe_q[1:0]};
            p_wdata = {16'h0000, mwd_q[15:0]};
        end
    end
endmodule

// File: rtl/hw_split_bridge.sv
module hw_split_bridge
    import hsb_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int LW_W   = 2,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int AW     = 1 + SLOT_W + LW_W,
    localparam int PAW    = LW_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              h_req,
    input  logic              h_we,
    input  logic [AW-1:0]     h_addr,
    input  logic [3:0]        h_be,
    input  logic [31:0]       h_wdata,
    output logic              h_ack,
    output logic [31:0]       h_rdata,
    input  logic [SLOTS-1:0]  bswap,
    input  logic [SLOTS-1:0]  wswap,
    output logic              p_stb,
    output logic              p_we,
    output logic              p_wide,
    output logic [SLOT_W-1:0] p_sel,
    output logic [PAW-1:0]    p_addr,
    output logic [3:0]        p_be,
    output logic [31:0]       p_wdata,
    input  logic              p_ack,
    input  logic [31:0]       p_rdata
);
    lane_cfg_t         cfg;
    lane_cfg_t         cfg_q;
    logic [SLOT_W-1:0] slot;
    logic [LW_W-1:0]   lw;
    logic [3:0]        mbe;
    logic [31:0]       mwd;
    logic [31:0]       raw_q;
    logic [3:0]        hbe_q;
    logic [31:0]       rd_unswapped;

    hsb_decode #(.SLOTS(SLOTS), .LW_W(LW_W)) u_dec (
        .addr(h_addr), .bswap(bswap), .wswap(wswap),
        .cfg(cfg), .slot(slot), .lw(lw)
    );

    hsb_lane_swap #(.INVERSE(1'b0)) u_wr_swap (
        .din(h_wdata), .cfg(cfg), .dout(mwd)
    );

    assign mbe = strobe_map(h_be, cfg);

    hsb_seq #(.SLOTS(SLOTS), .LW_W(LW_W)) u_seq (
        .clk(clk), .rst(rst),
        .h_req(h_req), .h_we(h_we), .cfg(cfg), .slot(slot), .lw(lw),
        .hbe(h_be), .mbe(mbe), .mwd(mwd),
        .h_ack(h_ack), .raw_q(raw_q), .hbe_q(hbe_q), .cfg_q(cfg_q),
        .p_stb(p_stb), .p_we(p_we), .p_wide(p_wide), .p_sel(p_sel),
        .p_addr(p_addr), .p_be(p_be), .p_wdata(p_wdata),
        .p_ack(p_ack), .p_rdata(p_rdata)
    );

    hsb_lane_swap #(.INVERSE(1'b1)) u_rd_swap (
        .din(raw_q), .cfg(cfg_q), .dout(rd_unswapped)
    );

    assign h_rdata = rd_unswapped & lane_mask(hbe_q);
endmodule

// File: rtl/hsb_chk.sv
module hsb_chk #(
    parameter int SLOTS  = 4,
    parameter int LW_W   = 2,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int PAW    = LW_W + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              h_ack,
    input logic              p_stb,
    input logic              p_ack,
    input logic              p_wide,
    input logic [SLOT_W-1:0] p_sel,
    input logic [PAW-1:0]    p_addr,
    input logic [3:0]        p_be,
    input logic [31:0]       p_wdata
);
    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        p_stb && !p_ack |=> p_stb && $stable(p_addr) && $stable(p_be) && $stable(p_wdata));

    assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        h_ack |=> !h_ack);

    assert_ack_follows_bus_R10: assert property (@(posedge clk) disable iff (rst)
        h_ack |-> $past(p_ack) && $past(p_stb) && !p_stb);

    assert_narrow_lanes_R1: assert property (@(posedge clk) disable iff (rst)
        p_stb && !p_wide |-> p_be[3:2] == 2'b00 && p_wdata[31:16] == 16'h0000);

    assert_split_order_R1: assert property (@(posedge clk) disable iff (rst)
        p_stb && !p_wide && $past(p_stb) && $past(p_ack)
        |-> p_addr[0] && p_addr == $past(p_addr) + PAW'(1));

    assert_wide_even_R4: assert property (@(posedge clk) disable iff (rst)
        p_stb && p_wide |-> !p_addr[0]);

    assert_pair_sel_R5: assert property (@(posedge clk) disable iff (rst)
        p_stb && p_wide |-> p_sel[0]);
endmodule

bind hw_split_bridge hsb_chk #(.SLOTS(SLOTS), .LW_W(LW_W)) u_chk (
    .clk(clk), .rst(rst), .h_ack(h_ack), .p_stb(p_stb), .p_ack(p_ack),
    .p_wide(p_wide), .p_sel(p_sel), .p_addr(p_addr), .p_be(p_be),
    .p_wdata(p_wdata)
);

// File: tb/sim_hw_split_bridge.sv
`timescale 1ns/1ps
module sim_hw_split_bridge;
    localparam int SLOTS = 4;
    localparam int LW_W  = 2;
    localparam int SW    = 2;
    localparam int AW    = 1 + SW + LW_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic h_req = 1'b0, h_we = 1'b0;
    logic [AW-1:0] h_addr = '0;
    logic [3:0]  h_be = '0;
    logic [31:0] h_wdata = '0;
    logic h_ack;
    logic [31:0] h_rdata;
    logic [SLOTS-1:0] bswap = '0, wswap = '0;
    logic p_stb, p_we, p_wide;
    logic [SW-1:0] p_sel;
    logic [LW_W:0] p_addr;
    logic [3:0] p_be;
    logic [31:0] p_wdata;
    logic p_ack = 1'b0;
    logic [31:0] p_rdata = '0;

    int total = 0, bad = 0;
    logic [7:0] pm [64] = '{default: 8'h00};
    logic [7:0] em [64] = '{default: 8'h00};
    logic [LW_W:0] alog [16];
    int ncyc = 0;
    int mb;

    always #5 clk = ~clk;

    hw_split_bridge #(.SLOTS(SLOTS), .LW_W(LW_W)) u0 (
        .clk(clk), .rst(rst), .h_req(h_req), .h_we(h_we), .h_addr(h_addr),
        .h_be(h_be), .h_wdata(h_wdata), .h_ack(h_ack), .h_rdata(h_rdata),
        .bswap(bswap), .wswap(wswap), .p_stb(p_stb), .p_we(p_we),
        .p_wide(p_wide), .p_sel(p_sel), .p_addr(p_addr), .p_be(p_be),
        .p_wdata(p_wdata), .p_ack(p_ack), .p_rdata(p_rdata)
    );

    // Device model: acknowledges one clock after it sees a strobe.
    always @(posedge clk) begin
        if (rst) begin
            p_ack <= 1'b0;
        end else if (p_stb && !p_ack) begin
            mb = int'(p_sel) * 16 + int'(p_addr) * 2;
            p_ack <= 1'b1;
            alog[ncyc % 16] <= p_addr;
            ncyc <= ncyc + 1;
            if (p_we)
                for (int k = 0; k < (p_wide ? 4 : 2); k++)
                    if (p_be[k]) pm[mb + k] <= p_wdata[8*k +: 8];
            p_rdata <= p_wide ? {pm[mb+3], pm[mb+2], pm[mb+1], pm[mb]}
                              : {16'h0000, pm[mb+1], pm[mb]};
        end else begin
            p_ack <= 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int dest(input int j, input bit wide, input bit bs, input bit ws);
        int t;
        t = ws ? (j ^ 2) : j;
        if (bs) t = wide ? (3 - t) : (t ^ 1);
        return t;
    endfunction

    task automatic host(input bit we, input bit win, input int slot, input int lw,
                        input logic [3:0] be, input logic [31:0] d,
                        output logic [31:0] r, output int waits);
        @(negedge clk);
        h_we = we; h_addr = {win, SW'(slot), LW_W'(lw)}; h_be = be; h_wdata = d;
        h_req = 1'b1;
        waits = 0;
        do begin
            @(negedge clk);
            waits++;
        end while (!h_ack && waits < 50);
        r = h_rdata;
        h_req = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        int waits, c0, es, base, n, tmp;
        bit bs, ws;
        logic [3:0] bep;
        logic [31:0] d, act, exp;
        string tg;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 reset strobe low", {31'b0, p_stb}, 32'h0);
        chk("R10 reset ack low", {31'b0, h_ack}, 32'h0);
        rst = 1'b0;

        // R6 directed: 16-bit byte swap, 0x1234 -> 0x3412 on the bus
        bswap = 4'b0001; wswap = 4'b0000;
        host(1'b1, 1'b0, 0, 0, 4'b0011, 32'h0000_1234, r, waits);
        chk("R6 16-bit byte swap", {16'h0, pm[1], pm[0]}, 32'h0000_3412);
        em[0] = 8'h12; em[1] = 8'h34;
        // R7 directed: 32-bit reverse via pair (0,1), odd slot controls
        bswap = 4'b0010;
        host(1'b1, 1'b1, 0, 0, 4'b1111, 32'h1234_5678, r, waits);
        chk("R7 R5 32-bit byte reverse", {pm[19], pm[18], pm[17], pm[16]}, 32'h7856_3412);
        em[16] = 8'h12; em[17] = 8'h34; em[18] = 8'h56; em[19] = 8'h78;

        for (int c = 0; c < 16; c++) begin
            for (int i = 0; i < SLOTS; i++) begin
                bswap[i] = c[0] ^ ((i % 2 == 0) && c[2]);
                wswap[i] = c[1] ^ ((i % 2 == 0) && c[3]);
            end
            for (int win = 0; win < 2; win++)
                for (int s = 0; s < SLOTS; s++)
                    for (int b = 0; b < 16; b++) begin
                        int lw;
                        lw = (b + s + c) % 4;
                        d = 32'h1234_5678 ^ (32'(c * 64 + win * 32 + s * 16 + b) * 32'h9E37_79B9);
                        es = win ? (s | 1) : s;
                        bs = bswap[es]; ws = wswap[es];
                        base = es * 16 + lw * 4;
                        bep = '0;
                        for (int j = 0; j < 4; j++)
                            if (b[j]) begin
                                tmp = dest(j, win[0], bs, ws);
                                bep[tmp] = 1'b1;
                                em[base + tmp] = d[8*j +: 8];
                            end
                        if (win) n = 1;
                        else begin
                            n = int'(bep[1:0] != 0) + int'(bep[3:2] != 0);
                            if (n == 0) n = 1;
                        end
                        c0 = ncyc;
                        host(1'b1, win[0], s, lw, 4'(b), d, r, waits);
                        chk("R1 R3 R4 cycle count", 32'(ncyc - c0), 32'(n));
                        chk("R2 R1 first halfword address", 32'(alog[c0 % 16]),
                            32'({LW_W'(lw), (!win[0] && bep[1:0] == 0 && bep != 0)}));
                        if (n == 2)
                            chk("R1 second halfword address", 32'(alog[(c0 + 1) % 16]),
                                32'({LW_W'(lw), 1'b1}));
                        chk("R10 write ack latency", 32'(waits), 32'(2 * n + 1));
                        act = {pm[base+3], pm[base+2], pm[base+1], pm[base]};
                        exp = {em[base+3], em[base+2], em[base+1], em[base]};
                        if (!bs && !ws) tg = "R12 straight";
                        else if (ws) tg = "R8 word swap";
                        else tg = win ? "R7 reverse" : "R6 halfword swap";
                        if (win) tg = {"R5 pair ", tg};
                        chk(tg, act, exp);
                        host(1'b0, win[0], s, lw, 4'(b), 32'hDEAD_BEEF, r, waits);
                        exp = 0;
                        for (int j = 0; j < 4; j++)
                            if (b[j]) exp[8*j +: 8] = d[8*j +: 8];
                        chk("R9 read-back under enables", r, exp);
                        chk("R10 read ack latency", 32'(waits), 32'(2 * n + 1));
                    end
        end
        finish_run();
    end
endmodule